// File: doc/BRIEF.md
# Synchronous Serial Port Clock Generator and Control Word

This block holds the configuration word of a synchronous serial port and turns it into the serial clock and the per-edge strobes that a shift engine uses to launch and capture bits. The word carries an 8-bit rate divisor, an enable bit, a clock source select bit and a two-bit frame format. The serial clock is the selected reference divided by two times (divisor + 1). The reference is either the system clock or an external clock input. The external clock is brought into the system domain by a two-stage synchronizer, and each rising edge found there counts as one reference tick.

A three-state machine makes the serial clock. SCK_IDLE holds the clock low while the port is disabled. SCK_LOW and SCK_HIGH each last divisor+1 ticks. The transitions are:
- IDLE→LOW when enable is written to 1.
- LOW→HIGH at terminal count. This is the rising edge.
- HIGH→LOW at terminal count. This is the falling edge and the end of a period. Divisor and source writes are adopted here.
- Any state→IDLE as soon as enable is written to 0.

Clearing enable cuts the running frame, drops the clock at once and issues a one-cycle FIFO flush pulse. The configuration fields keep their values.

Top module: `sspc_top`

## Requirements
- R1: After reset the port is disabled: `port_en`, `sclk_out`, `drive_stb`, `sample_stb` and `fifo_flush` are all 0, and bit 7 of `rd_data` reads 0.
- R2: The word layout is divisor in bits 15:8, enable in bit 7, source select in bit 6 and frame format in bits 5:4. Bits 31:16 and 3:0 always read 0 and ignore writes.
- R3: With source select 0, each low phase and each high phase of `sclk_out` lasts exactly divisor+1 system clock cycles. The first phase after enable is a full low phase that begins in the cycle after the enabling write.
- R4: While enable is 0, `sclk_out`, `drive_stb` and `sample_stb` stay 0.
- R5: A write that clears enable while the port runs forces `sclk_out` low in the following cycle. In that same cycle `fifo_flush` is 1, and it is 0 again in the cycle after.
- R6: A divisor written while the port runs does not alter the current period. It governs phases from the next falling edge of `sclk_out` onward.
- R7: With source select 1, one tick is each rising edge of `ext_clk` after the two-flop synchronizer, and each phase of `sclk_out` lasts divisor+1 ticks.
- R8: A strobe fires in the cycle in which `sclk_out` changes. For format 01, `drive_stb` marks rising edges and `sample_stb` marks falling edges. For formats 00, 10 and 11, `drive_stb` marks falling edges and `sample_stb` marks rising edges. Neither strobe fires in any other cycle.
- R9: `frame_fmt` presents the stored frame format field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal reference |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read data |
| ext_clk | input | 1 | External reference clock, asynchronous |
| sclk_out | output | 1 | Serial clock |
| drive_stb | output | 1 | Launch strobe for transmit data |
| sample_stb | output | 1 | Capture strobe for receive data |
| port_en | output | 1 | Current enable bit |
| frame_fmt | output | 2 | Current frame format |
| fifo_flush | output | 1 | One-cycle FIFO reset pulse on disable |

## Verification
Two things can coincide with a serial clock edge: the disable abort and the adoption of a staged divisor. The bench provokes the abort by clearing enable in the first cycle of a high phase. It then checks that the next cycle shows the clock low, the flush pulse and no falling-edge strobe. The bench provokes a divisor change by writing inside a high phase. It judges the result by measuring that the rest of the high phase keeps the old length and that the following low phase already uses the new one.

// File: rtl/sspc_pkg.sv
`timescale 1ns/1ps
package sspc_pkg;

    typedef enum logic [1:0] {
        FMT_SPI   = 2'b00,
        FMT_SYNC  = 2'b01,
        FMT_UWIRE = 2'b10,
        FMT_RSVD  = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        SCK_IDLE = 2'b00,
        SCK_LOW  = 2'b01,
        SCK_HIGH = 2'b10
    } sck_state_e;

endpackage

// File: rtl/sspc_cfg_reg.sv
`timescale 1ns/1ps
module sspc_cfg_reg #(
    parameter int WORD_W  = 32,
    parameter int SCR_W   = 8,
    parameter int SCR_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic [SCR_W-1:0]  scr_d,
    output logic              ecs_d,
    output logic              sse_d,
    output logic              sse_q,
    output logic [1:0]        frf_q,
    output logic              flush_q
);
    localparam int SSE_BIT = SCR_LSB - 1;
    localparam int ECS_BIT = SCR_LSB - 2;
    localparam int FRF_LSB = SCR_LSB - 4;
    localparam int TOP_BIT = SCR_LSB + SCR_W;

    logic [SCR_W-1:0] scr_q;
    logic             ecs_q;
    logic             unused_wr;

    assign unused_wr = ^{wr_data[WORD_W-1:TOP_BIT], wr_data[FRF_LSB-1:0]};

    // Values a write in this cycle will leave in the word.
    assign scr_d = wr_en ? wr_data[SCR_LSB +: SCR_W] : scr_q;
    assign ecs_d = wr_en ? wr_data[ECS_BIT]          : ecs_q;
    assign sse_d = wr_en ? wr_data[SSE_BIT]          : sse_q;

    // Only the enable bit and the flush pulse are reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sse_q   <= 1'b0;
            flush_q <= 1'b0;
        end else begin
            sse_q   <= sse_d;
            flush_q <= sse_q & ~sse_d;
        end
    end

    // Configuration fields have no reset and survive a disable.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            scr_q <= wr_data[SCR_LSB +: SCR_W];
            ecs_q <= wr_data[ECS_BIT];
            frf_q <= wr_data[FRF_LSB +: 2];
        end
    end

    always_comb begin
        rd_data                    = '0;
        rd_data[SCR_LSB +: SCR_W]  = scr_q;
        rd_data[SSE_BIT]           = sse_q;
        rd_data[ECS_BIT]           = ecs_q;
        rd_data[FRF_LSB +: 2]      = frf_q;
    end

endmodule

// File: rtl/sspc_ext_sync.sv
`timescale 1ns/1ps
module sspc_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk,
    output logic ext_tick
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= ext_clk;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= 1'b0;
            else        chain[g] <= chain[g-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[STAGES-1];
    end

    assign ext_tick = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/sspc_clk_gen.sv
`timescale 1ns/1ps
module sspc_clk_gen
    import sspc_pkg::*;
#(
    parameter int SCR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sse_d,
    input  logic [SCR_W-1:0] scr_d,
    input  logic             ecs_d,
    input  logic             ext_tick,
    output logic             sclk,
    output logic             rise_stb,
    output logic             fall_stb
);
    sck_state_e       state, state_n;
    logic [SCR_W-1:0] cnt, cnt_n;
    logic [SCR_W-1:0] act_scr, act_scr_n;
    logic             act_ecs, act_ecs_n;
    logic             rise_q, rise_n, fall_q, fall_n;
    logic             tick, last;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SCK_IDLE;
            cnt     <= '0;
            act_scr <= '0;
            act_ecs <= 1'b0;
            rise_q  <= 1'b0;
            fall_q  <= 1'b0;
        end else begin
            state   <= state_n;
            cnt     <= cnt_n;
            act_scr <= act_scr_n;
            act_ecs <= act_ecs_n;
            rise_q  <= rise_n;
            fall_q  <= fall_n;
        end
    end

    assign tick = act_ecs ? ext_tick : 1'b1;
    assign last = (cnt == act_scr);

    // Next state and edge decisions.
    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        act_scr_n = act_scr;
        act_ecs_n = act_ecs;
        rise_n    = 1'b0;
        fall_n    = 1'b0;
        unique case (state)
            SCK_IDLE: begin
                if (sse_d) begin
                    state_n   = SCK_LOW;
                    cnt_n     = '0;
                    act_scr_n = scr_d;
                    act_ecs_n = ecs_d;
                end
            end
            SCK_LOW: begin
                if (tick) begin
                    if (last) begin
                        state_n = SCK_HIGH;
                        cnt_n   = '0;
                        rise_n  = 1'b1;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            SCK_HIGH: begin
                if (tick) begin
                    if (last) begin
                        state_n   = SCK_LOW;
                        cnt_n     = '0;
                        fall_n    = 1'b1;
                        act_scr_n = scr_d;
                        act_ecs_n = ecs_d;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            default: state_n = SCK_IDLE;
        endcase
        if (!sse_d) begin
            state_n = SCK_IDLE;
            cnt_n   = '0;
            rise_n  = 1'b0;
            fall_n  = 1'b0;
        end
    end

    // Outputs.
    always_comb begin
        sclk     = (state == SCK_HIGH);
        rise_stb = rise_q;
        fall_stb = fall_q;
    end

endmodule

// File: rtl/sspc_edge_sel.sv
`timescale 1ns/1ps
module sspc_edge_sel
    import sspc_pkg::*;
(
    input  logic [1:0] frf,
    input  logic       rise_stb,
    input  logic       fall_stb,
    output logic       drive_stb,
    output logic       sample_stb
);
    always_comb begin
        unique case (fmt_e'(frf))
            FMT_SYNC: begin
                drive_stb  = rise_stb;
                sample_stb = fall_stb;
            end
            FMT_SPI, FMT_UWIRE, FMT_RSVD: begin
                drive_stb  = fall_stb;
                sample_stb = rise_stb;
            end
            default: begin
                drive_stb  = fall_stb;
                sample_stb = rise_stb;
            end
        endcase
    end
endmodule

// File: rtl/sspc_top.sv
`timescale 1ns/1ps
module sspc_top #(
    parameter int WORD_W      = 32,
    parameter int SCR_W       = 8,
    parameter int SCR_LSB     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              ext_clk,
    output logic              sclk_out,
    output logic              drive_stb,
    output logic              sample_stb,
    output logic              port_en,
    output logic [1:0]        frame_fmt,
    output logic              fifo_flush
);
    logic [SCR_W-1:0] scr_d;
    logic             ecs_d, sse_d, sse_q, flush_q;
    logic [1:0]       frf_q;
    logic             ext_tick, rise_stb, fall_stb;

    sspc_cfg_reg #(.WORD_W(WORD_W), .SCR_W(SCR_W), .SCR_LSB(SCR_LSB)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .scr_d(scr_d), .ecs_d(ecs_d), .sse_d(sse_d),
        .sse_q(sse_q), .frf_q(frf_q), .flush_q(flush_q)
    );

    sspc_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .ext_tick(ext_tick)
    );

    sspc_clk_gen #(.SCR_W(SCR_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .sse_d(sse_d), .scr_d(scr_d),
        .ecs_d(ecs_d), .ext_tick(ext_tick), .sclk(sclk_out),
        .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    sspc_edge_sel u_edge (
        .frf(frf_q), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .drive_stb(drive_stb), .sample_stb(sample_stb)
    );

    assign port_en    = sse_q;
    assign frame_fmt  = frf_q;
    assign fifo_flush = flush_q;

endmodule

// File: rtl/sspc_checker.sv
`timescale 1ns/1ps
module sspc_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] rd_data,
    input logic              sclk_out,
    input logic              drive_stb,
    input logic              sample_stb,
    input logic              port_en,
    input logic              fifo_flush
);
    // R4: no clock while disabled
    p_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> (!sclk_out && !drive_stb && !sample_stb));

    // R5: flush pulse lasts one cycle
    p_flush_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> !fifo_flush);

    // R5: flush only after enable fell
    p_flush_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |-> (!port_en && $past(port_en)));

    // R8: strobes never together, and only on clock changes
    p_strobe_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drive_stb, sample_stb}));

    p_strobe_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_stb || sample_stb) |-> !$stable(sclk_out));

    p_rise_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_out) |-> (drive_stb || sample_stb));

    // R2: reserved bits read zero
    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[WORD_W-1:16] == '0) && (rd_data[3:0] == 4'h0));
endmodule

bind sspc_top sspc_checker #(.WORD_W(WORD_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .sclk_out(sclk_out),
    .drive_stb(drive_stb), .sample_stb(sample_stb), .port_en(port_en),
    .fifo_flush(fifo_flush)
);

// File: tb/sspc_top_tb_top.sv
`timescale 1ns/1ps
module sspc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ext_clk = 1'b0;
    logic        ext_run = 1'b0;
    logic        sclk_out, drive_stb, sample_stb, port_en, fifo_flush;
    logic [1:0]  frame_fmt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;
    always #80 ext_clk = ext_run ? ~ext_clk : 1'b0;

    sspc_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ext_clk(ext_clk), .sclk_out(sclk_out),
        .drive_stb(drive_stb), .sample_stb(sample_stb), .port_en(port_en),
        .frame_fmt(frame_fmt), .fifo_flush(fifo_flush)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word(input int scr, input bit en,
                                         input bit src, input int fmt);
        return {16'h0, scr[7:0], en, src, fmt[1:0], 4'h0};
    endfunction

    // Drive one write at a falling edge; returns one cycle after it lands.
    task automatic bus_write(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count consecutive samples (from the current one) at level lvl.
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (sclk_out == lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_high();
        int g = 0;
        while (sclk_out !== 1'b1 && g < 5000) begin
            g++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check(port_en == 0 && rd_data[7] == 0, "R1 enable", int'(port_en), 0);
        check(!sclk_out && !drive_stb && !sample_stb && !fifo_flush,
              "R1 outputs", int'({sclk_out, drive_stb, sample_stb, fifo_flush}), 0);
    endtask

    task automatic t_readback();
        bus_write(32'hFFFF_FF7F);
        check(rd_data == 32'h0000_FF70, "R2 readback ones", int'(rd_data), 32'hFF70);
        check(frame_fmt == 2'b11, "R9 format", int'(frame_fmt), 3);
        bus_write(32'hA5A5_5A2A);
        check(rd_data == 32'h0000_5A20, "R2 readback mix", int'(rd_data), 32'h5A20);
        check(frame_fmt == 2'b10, "R9 format", int'(frame_fmt), 2);
        check(sclk_out == 0, "R4 disabled", int'(sclk_out), 0);
    endtask

    task automatic t_rate(input int n);
        int lo0, hi, lo;
        bus_write(word(n, 1, 0, 0));
        run_len(1'b0, lo0);
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        check(lo0 == n + 1, "R3 first low", lo0, n + 1);
        check(hi == n + 1, "R3 high", hi, n + 1);
        check(lo == n + 1, "R3 low", lo, n + 1);
        bus_write(word(n, 0, 0, 0));
    endtask

    task automatic t_rate_change();
        int hi_rest, lo, hi;
        bus_write(word(3, 1, 0, 0));
        wait_high();
        bus_write(word(0, 1, 0, 0));
        run_len(1'b1, hi_rest);
        run_len(1'b0, lo);
        run_len(1'b1, hi);
        check(hi_rest == 2, "R6 old period kept", hi_rest, 2);
        check(lo == 1, "R6 new low", lo, 1);
        check(hi == 1, "R6 new high", hi, 1);
        bus_write(word(0, 0, 0, 0));
    endtask

    task automatic t_abort();
        bus_write(word(2, 1, 0, 0));
        wait_high();
        wr_en = 1'b1; wr_data = word(2, 0, 0, 0);
        @(negedge clk);
        wr_en = 1'b0;
        check(sclk_out == 0, "R5 clock dropped", int'(sclk_out), 0);
        check(fifo_flush == 1, "R5 flush", int'(fifo_flush), 1);
        check(!drive_stb && !sample_stb, "R5 no strobe", int'({drive_stb, sample_stb}), 0);
        check(port_en == 0 && rd_data[15:8] == 8'd2, "R5 config kept",
              int'(rd_data[15:8]), 2);
        @(negedge clk);
        check(fifo_flush == 0, "R5 flush single", int'(fifo_flush), 0);
        begin
            int bad = 0;
            for (int i = 0; i < 40; i++) begin
                if (sclk_out || drive_stb || sample_stb) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R4 quiet", bad, 0);
        end
    endtask

    task automatic t_format(input int f);
        bit drv_on_rise = (f == 1);
        int hi;
        bus_write(word(1, 1, 0, f));
        wait_high();
        check(frame_fmt == f[1:0], "R9 format out", int'(frame_fmt), f);
        check(drive_stb == drv_on_rise && sample_stb == !drv_on_rise,
              "R8 rising strobes", int'({drive_stb, sample_stb}),
              int'({drv_on_rise, !drv_on_rise}));
        @(negedge clk);
        check(!drive_stb && !sample_stb, "R8 mid phase", int'({drive_stb, sample_stb}), 0);
        run_len(1'b1, hi);
        check(drive_stb == !drv_on_rise && sample_stb == drv_on_rise,
              "R8 falling strobes", int'({drive_stb, sample_stb}),
              int'({!drv_on_rise, drv_on_rise}));
        bus_write(word(1, 0, 0, f));
    endtask

    task automatic t_external(input int n);
        int hi, lo;
        ext_run = 1'b1;
        repeat (20) @(negedge clk);
        bus_write(word(n, 1, 1, 0));
        wait_high();
        run_len(1'b1, hi);
        run_len(1'b0, lo);
        check(hi == 8 * (n + 1), "R7 ext high", hi, 8 * (n + 1));
        check(lo == 8 * (n + 1), "R7 ext low", lo, 8 * (n + 1));
        bus_write(word(n, 0, 1, 0));
        ext_run = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_rate(0);
        t_rate(1);
        t_rate(3);
        t_rate(7);
        t_rate_change();
        t_abort();
        t_format(0);
        t_format(1);
        t_format(2);
        t_external(0);
        t_external(1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule